// File: doc/BRIEF.md
# Transceiver Operating Mode Controller

This block chooses the operating mode of a radio transceiver from one 8-bit control register. The register has three mode-enable bits: transmit, synthesizer (PLL) and crystal oscillator. Whenever the register changes, the mode is recomputed. The highest-priority set bit wins: TX, then TUNE, then READY. STANDBY is chosen only when the register is all zero. The block drives the oscillator and PLL enables for each mode. The transmit enable follows once a short settle counter has run out in TX.

The host starts a packet by setting the transmit bit. When the transmitter reports with a one-cycle packet-sent pulse that the transmit buffer has drained, the controller clears the transmit bit by itself. It then drops to the mode named by the bits that remain. If no bit remains, it drops to READY with the oscillator still running. The block never returns to STANDBY on its own. The host must write zero to reach the lowest-power state, so a clock taken from the oscillator keeps running until the host has dealt with the event.

Top module: `trx_mode_ctrl`

## Requirements
- R1: While reset is asserted and after reset, the register reads 0x00, the mode is STANDBY (code 0) and all three enables are low.
- R2: A write stores only bit 3 (transmit), bit 1 (PLL) and bit 0 (oscillator). All other bits read as zero. The new value is visible on the readback and the mode in the cycle after the write.
- R3: The mode codes are STANDBY=0, READY=1, TUNE=2 and TX=3. The mode is TX if bit 3 is set, otherwise TUNE if bit 1 is set, otherwise READY if bit 0 is set, otherwise STANDBY.
- R4: The oscillator enable is high in every mode except STANDBY. The PLL enable is high only in TUNE and TX.
- R5: The transmit enable is high only in TX. It rises SETTLE_CYC cycles after the mode enters TX (4 by default).
- R6: A packet-sent pulse in TX clears bit 3 and keeps bits 1 and 0. The mode falls back to the mode those bits select: 0x0A goes to TUNE and 0x09 goes to READY.
- R7: If no other bit is left after the clear (a write of 0x08 followed by packet-sent), bit 0 is set. The register reads 0x01 and the mode is READY, not STANDBY.
- R8: A packet-sent pulse outside TX changes neither the register nor the mode.
- R9: STANDBY is reached only through a write that leaves the register zero. No other event moves the mode from a non-zero code to 0.
- R10: If a write and a packet-sent pulse fall in the same cycle, the write decides the register value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| wr_en | input | 1 | Control register write strobe |
| wr_data | input | 8 | Control register write value |
| pkt_sent | input | 1 | One-cycle pulse from the transmitter: the packet is out |
| ctrl_rd | output | 8 | Current control register contents |
| mode_o | output | 2 | Current mode code (0 STANDBY, 1 READY, 2 TUNE, 3 TX) |
| xtal_en | output | 1 | Crystal oscillator enable |
| pll_en | output | 1 | Synthesizer enable |
| tx_en | output | 1 | Transmit enable, high after settling in TX |

## Verification
The bench checks the fallback after packet-sent for each leftover-bit pattern. A design that returned straight to STANDBY would drop the oscillator and read 0x00 after a lone 0x08. A design that forgot the leftover bits would lose TUNE after 0x0A. It also sends packet-sent outside TX, where a careless clear would change the register, and collides a write with packet-sent, where the wrong priority would wipe the host's new value. Writes with reserved bits set, and the exact cycle the transmit enable rises, are checked against an off-by-one settle count.

// File: rtl/trxm_pkg.sv
package trxm_pkg;
  localparam int CTRL_W   = 8;
  localparam int TX_BIT   = 3;
  localparam int PLL_BIT  = 1;
  localparam int XTAL_BIT = 0;
  localparam logic [CTRL_W-1:0] KEEP_MASK =
    CTRL_W'((1 << TX_BIT) | (1 << PLL_BIT) | (1 << XTAL_BIT));

  typedef enum logic [1:0] {
    MODE_STANDBY = 2'd0,
    MODE_READY   = 2'd1,
    MODE_TUNE    = 2'd2,
    MODE_TX      = 2'd3
  } trx_mode_e;

  function automatic trx_mode_e mode_of(input logic [CTRL_W-1:0] c);
    if (c[TX_BIT])        return MODE_TX;
    else if (c[PLL_BIT])  return MODE_TUNE;
    else if (c[XTAL_BIT]) return MODE_READY;
    else                  return MODE_STANDBY;
  endfunction
endpackage

// File: rtl/trxm_rst_sync.sv
module trxm_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_sync = chain_q[STAGES-1];
endmodule

// File: rtl/trxm_ctrl_reg.sv
module trxm_ctrl_reg
  import trxm_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [CTRL_W-1:0] wr_data,
  input  logic              pkt_sent,
  input  logic              in_tx,
  output logic [CTRL_W-1:0] ctrl_q,
  output logic [CTRL_W-1:0] ctrl_d
);
  logic              upd_en;
  logic [CTRL_W-1:0] after_tx;

  always_comb begin
    after_tx         = ctrl_q;
    after_tx[TX_BIT] = 1'b0;
    // leave TX into READY, never into STANDBY
    if ((after_tx & KEEP_MASK) == '0) after_tx[XTAL_BIT] = 1'b1;
  end

  always_comb begin
    upd_en = 1'b0;
    ctrl_d = ctrl_q;
    if (wr_en) begin
      upd_en = 1'b1;
      ctrl_d = wr_data & KEEP_MASK;
    end else if (pkt_sent && in_tx) begin
      upd_en = 1'b1;
      ctrl_d = after_tx;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      ctrl_q <= '0;
    else if (upd_en) ctrl_q <= ctrl_d;
  end
endmodule

// File: rtl/trxm_settle.sv
module trxm_settle #(
  parameter int SETTLE_CYC = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic in_tx,
  output logic done
);
  generate
    if (SETTLE_CYC == 0) begin : g_none
      assign done = in_tx;
    end else begin : g_cnt
      localparam int CW = $clog2(SETTLE_CYC + 1);
      logic [CW-1:0] cnt_q, cnt_d;
      logic          cnt_en;

      always_comb begin
        cnt_en = 1'b0;
        cnt_d  = cnt_q;
        if (!in_tx) begin
          cnt_en = (cnt_q != '0);
          cnt_d  = '0;
        end else if (cnt_q != CW'(SETTLE_CYC)) begin
          cnt_en = 1'b1;
          cnt_d  = cnt_q + 1'b1;
        end
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      cnt_q <= '0;
        else if (cnt_en) cnt_q <= cnt_d;
      end

      assign done = in_tx && (cnt_q == CW'(SETTLE_CYC));
    end
  endgenerate
endmodule

// File: rtl/trx_mode_ctrl.sv
module trx_mode_ctrl
  import trxm_pkg::*;
#(
  parameter int SETTLE_CYC = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic [7:0]  wr_data,
  input  logic        pkt_sent,
  output logic [7:0]  ctrl_rd,
  output logic [1:0]  mode_o,
  output logic        xtal_en,
  output logic        pll_en,
  output logic        tx_en
);
  logic              rst_int_n;
  logic [CTRL_W-1:0] ctrl_q, ctrl_d;
  trx_mode_e         mode_q, mode_d;
  logic              in_tx, settled;

  trxm_rst_sync #(.STAGES(SYNC_STAGES)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_n_sync(rst_int_n)
  );

  assign in_tx = (mode_q == MODE_TX);

  trxm_ctrl_reg u_reg (
    .clk(clk), .rst_n(rst_int_n), .wr_en(wr_en), .wr_data(wr_data),
    .pkt_sent(pkt_sent), .in_tx(in_tx), .ctrl_q(ctrl_q), .ctrl_d(ctrl_d)
  );

  always_comb mode_d = mode_of(ctrl_d);

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) mode_q <= MODE_STANDBY;
    else            mode_q <= mode_d;
  end

  trxm_settle #(.SETTLE_CYC(SETTLE_CYC)) u_settle (
    .clk(clk), .rst_n(rst_int_n), .in_tx(in_tx), .done(settled)
  );

  assign ctrl_rd = ctrl_q;
  assign mode_o  = mode_q;
  assign xtal_en = (mode_q != MODE_STANDBY);
  assign pll_en  = (mode_q == MODE_TUNE) || (mode_q == MODE_TX);
  assign tx_en   = settled;
endmodule

// File: rtl/trx_mode_ctrl_chk.sv
module trx_mode_ctrl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       wr_en,
  input logic       pkt_sent,
  input logic [7:0] ctrl_rd,
  input logic [1:0] mode_o,
  input logic       xtal_en,
  input logic       pll_en,
  input logic       tx_en
);
  // R3
  tx_bit_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_rd[3] |-> mode_o == 2'd3);

  // R4
  pll_needs_xtal_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pll_en |-> xtal_en);

  // R5
  tx_en_in_tx_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_en |-> mode_o == 2'd3);

  // R6
  pkt_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_o == 2'd3 && pkt_sent && !wr_en) |=> (!ctrl_rd[3] && mode_o != 2'd3));

  // R7
  no_drop_standby_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_o == 2'd3 && pkt_sent && !wr_en) |=> (xtal_en && ctrl_rd != 8'h00));

  // R8
  pkt_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_o != 2'd3 && pkt_sent && !wr_en) |=> ($stable(ctrl_rd) && $stable(mode_o)));

  // R9
  standby_by_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_en && mode_o != 2'd0) |=> mode_o != 2'd0);
endmodule

bind trx_mode_ctrl trx_mode_ctrl_chk u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .pkt_sent(pkt_sent),
  .ctrl_rd(ctrl_rd), .mode_o(mode_o), .xtal_en(xtal_en),
  .pll_en(pll_en), .tx_en(tx_en)
);

// File: tb/trx_mode_ctrl_test.sv
module trx_mode_ctrl_test;
  logic       clk;
  logic       rst_n;
  logic       wr_en;
  logic [7:0] wr_data;
  logic       pkt_sent;
  logic [7:0] ctrl_rd;
  logic [1:0] mode_o;
  logic       xtal_en, pll_en, tx_en;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  trx_mode_ctrl uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .pkt_sent(pkt_sent), .ctrl_rd(ctrl_rd), .mode_o(mode_o),
    .xtal_en(xtal_en), .pll_en(pll_en), .tx_en(tx_en)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  // {write value, expected readback, expected mode}
  localparam int NV = 10;
  localparam logic [17:0] VEC [NV] = '{
    {8'h00, 8'h00, 2'd0}, {8'h01, 8'h01, 2'd1}, {8'h02, 8'h02, 2'd2},
    {8'h03, 8'h03, 2'd2}, {8'h08, 8'h08, 2'd3}, {8'h0B, 8'h0B, 2'd3},
    {8'hFF, 8'h0B, 2'd3}, {8'hF4, 8'h00, 2'd0}, {8'hA5, 8'h01, 2'd1},
    {8'h0A, 8'h0A, 2'd3}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic chk_enables(input string req, input logic [1:0] m);
    chk(req, {31'd0, xtal_en}, {31'd0, m != 2'd0});
    chk(req, {31'd0, pll_en}, {31'd0, m >= 2'd2});
  endtask

  task automatic write(input logic [7:0] d, input logic with_pkt);
    wr_en = 1'b1; wr_data = d; pkt_sent = with_pkt;
    @(negedge clk);
    wr_en = 1'b0; pkt_sent = 1'b0;
  endtask

  task automatic pulse_pkt();
    pkt_sent = 1'b1;
    @(negedge clk);
    pkt_sent = 1'b0;
  endtask

  initial begin
    rst_n = 1'b0; wr_en = 1'b0; wr_data = 8'h00; pkt_sent = 1'b0;
    repeat (3) @(negedge clk);
    // R1 during reset
    chk("R1", {24'd0, ctrl_rd}, 32'h00);
    chk("R1", {30'd0, mode_o}, 32'd0);
    chk("R1", {29'd0, xtal_en, pll_en, tx_en}, 32'd0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R1", {24'd0, ctrl_rd}, 32'h00);
    chk("R1", {29'd0, xtal_en, pll_en, tx_en}, 32'd0);

    // R2, R3, R4: table walk
    for (int i = 0; i < NV; i++) begin
      write(VEC[i][17:10], 1'b0);
      chk("R2", {24'd0, ctrl_rd}, {24'd0, VEC[i][9:2]});
      chk("R3", {30'd0, mode_o}, {30'd0, VEC[i][1:0]});
      chk_enables("R4", VEC[i][1:0]);
    end

    // R5: settle timing from entry into TX
    write(8'h00, 1'b0);
    write(8'h08, 1'b0);
    chk("R5", {31'd0, tx_en}, 32'd0);
    repeat (3) @(negedge clk);
    chk("R5", {31'd0, tx_en}, 32'd0);
    @(negedge clk);
    chk("R5", {31'd0, tx_en}, 32'd1);

    // R7: lone transmit bit falls back to READY
    pulse_pkt();
    chk("R7", {24'd0, ctrl_rd}, 32'h01);
    chk("R7", {30'd0, mode_o}, 32'd1);
    chk("R7", {31'd0, xtal_en}, 32'd1);
    chk("R5", {31'd0, tx_en}, 32'd0);

    // R8: pulse in READY ignored
    pulse_pkt();
    chk("R8", {24'd0, ctrl_rd}, 32'h01);
    chk("R8", {30'd0, mode_o}, 32'd1);

    // R6: 0x0A -> TUNE, 0x09 -> READY
    write(8'h0A, 1'b0);
    repeat (2) @(negedge clk);
    pulse_pkt();
    chk("R6", {24'd0, ctrl_rd}, 32'h02);
    chk("R6", {30'd0, mode_o}, 32'd2);
    chk_enables("R6", 2'd2);
    write(8'h09, 1'b0);
    pulse_pkt();
    chk("R6", {24'd0, ctrl_rd}, 32'h01);
    chk("R6", {30'd0, mode_o}, 32'd1);

    // R8: pulse in TUNE ignored
    write(8'h02, 1'b0);
    pulse_pkt();
    chk("R8", {24'd0, ctrl_rd}, 32'h02);

    // R9: standby only via write of zero; pulse there ignored
    write(8'h00, 1'b0);
    chk("R9", {30'd0, mode_o}, 32'd0);
    pulse_pkt();
    chk("R9", {24'd0, ctrl_rd}, 32'h00);
    chk("R9", {31'd0, xtal_en}, 32'd0);

    // R10: write collides with packet-sent in TX
    write(8'h0B, 1'b0);
    write(8'h0A, 1'b1);
    chk("R10", {24'd0, ctrl_rd}, 32'h0A);
    chk("R10", {30'd0, mode_o}, 32'd3);

    // R1: reset in the middle of TX
    rst_n = 1'b0;
    @(negedge clk);
    chk("R1", {24'd0, ctrl_rd}, 32'h00);
    chk("R1", {29'd0, xtal_en, pll_en, tx_en}, 32'd0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule